// File: doc/BRIEF.md
# SD/MMC Host Register and Interrupt Front-End

This block is the software-visible register file of a simple SD/MMC host controller. A 32-bit bus master reads and writes word-indexed registers. The registers hold the command argument, a command word, the base address of the data buffer, the block geometry and the interrupt enables. The block passes all of them to a card-side engine, which lies outside it. Writing the command word launches a command: the block sends the engine a one-cycle start pulse together with the decoded command fields.

The engine reports progress with single-cycle event pulses: command finished, data finished and command timed out. It delivers responses through a capture strobe. The block latches these reports into sticky status bits and response words. It also samples the card-presence and write-protect inputs, and flags every change in card presence. A single level-sensitive interrupt line is raised while any enabled status bit is set. Software clears status bits by writing ones to them.

The bus address is a word index: byte offset = 4 × `bus_word_addr`. Reads are combinational from the current address.

Top module: `sdhost_regfront`

## Requirements
- R1: After a synchronous reset, every register reads zero, and `irq` and `cmd_start` are low.
- R2: Word index 1 (enable) keeps `bus_wdata[3:0]`. Index 2 (buffer base) and index 4 (argument) keep all 32 bits. Index 9 (block length minus one) and index 10 (block count minus one) keep bits 10:0. Each register reads back what it kept. Reads of indices 12 to 15 return zero.
- R3: A bus write to index 3 (command word) pulses `cmd_start` for exactly the one cycle after the write edge. During that cycle the outputs hold the decoded fields: opcode = bits 5:0, open-drain = bit 6, response type = bits 9:8, busy response = bit 11, command type = bits 13:12, read transfer = bit 15. Index 3 reads back only these bits.
- R4: A command-word write is ignored while `eng_busy` is high or `cmd_start` is high: no pulse is produced and the stored command word is unchanged.
- R5: When `rsp_valid` is high and `rsp_long` is high, the block captures the response as follows. Index 5 receives `rsp_data[127:96]`, index 6 receives bits 95:64, index 7 receives bits 63:32 and index 8 receives bits 31:0. When `rsp_valid` is high and `rsp_long` is low, index 5 receives `rsp_data[31:0]` and indices 6 to 8 become zero.
- R6: Status (index 0) has these bits: bit 0 = command end, bit 1 = data end, bit 2 = card presence change, bit 3 = command timeout. Each bit is set at the edge that samples its event. A write to index 0 clears the bits written as one. If a set and a clear reach the same bit in the same cycle, the set wins.
- R7: A timeout pulse and a command-end pulse in the same cycle set only bit 3. Bit 0 is not set.
- R8: Index 11 (card state) reads bit 0 = card present and bit 1 = write protected, each registered one edge after its input. A change of the presence input sets status bit 2. A change of the write-protect input alone does not.
- R9: `irq` is high exactly when any bit of (status AND enable) is set. It follows each status or enable update in the same cycle.
- R10: Writes to indices 5 to 8 and 11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_word_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from the address |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_opcode | output | 6 | Command opcode |
| cmd_open_drain | output | 1 | Open-drain bus mode for this command |
| cmd_rsp_type | output | 2 | 0 none, 1 short, 2 long 136-bit, 3 short without CRC check |
| cmd_busy_rsp | output | 1 | Response carries a busy phase |
| cmd_kind | output | 2 | 0 broadcast, 1 broadcast with response, 2 addressed, 3 addressed with data |
| cmd_read | output | 1 | Data phase moves data from the card |
| cmd_arg | output | 32 | Command argument |
| buf_base | output | 32 | Data buffer base address |
| blk_len_m1 | output | 11 | Block length minus one |
| blk_cnt_m1 | output | 11 | Block count minus one |
| eng_busy | input | 1 | Engine is executing a command |
| evt_cmd_done | input | 1 | Command-end event pulse |
| evt_data_done | input | 1 | Data-end event pulse |
| evt_cmd_timeout | input | 1 | Command-timeout event pulse |
| rsp_valid | input | 1 | Response capture strobe |
| rsp_long | input | 1 | Response is 136-bit |
| rsp_data | input | 128 | Response bits |
| card_present | input | 1 | Card presence input |
| card_ro | input | 1 | Card write-protect input |
| irq | output | 1 | Level interrupt |

## Verification
Each result of this block appears after exactly one clock edge from its stimulus. This holds for the start pulse and its fields, every status bit set by an event or presence change, a cleared bit, a captured response and the card-state reading. The interrupt line is combinational from status and enable. It therefore changes in that same cycle, and the bench checks it alongside them. The bench drives every stimulus at a falling edge and lets one rising edge pass. It samples at the next falling edge, and it reads registers combinationally at that same instant. The start pulse is also checked one further cycle later, which confirms that it lasts a single cycle.

// File: rtl/sdhost_regs_pkg.sv
package sdhost_regs_pkg;

    localparam int DATA_W     = 32;
    localparam int LEN_W      = 11;
    localparam int RESP_WORDS = 4;
    localparam int EVT_W      = 4;

    // register word indices (byte offset = 4 * index)
    localparam int W_STATUS = 0;
    localparam int W_ENABLE = 1;
    localparam int W_BUFFER = 2;
    localparam int W_CMD    = 3;
    localparam int W_ARG    = 4;
    localparam int W_RESP0  = 5;
    localparam int W_RESP1  = 6;
    localparam int W_RESP2  = 7;
    localparam int W_RESP3  = 8;
    localparam int W_BLKLEN = 9;
    localparam int W_BLKCNT = 10;
    localparam int W_CARD   = 11;

    // status bit positions
    localparam int B_CMD_END  = 0;
    localparam int B_DATA_END = 1;
    localparam int B_CARD_CHG = 2;
    localparam int B_TIMEOUT  = 3;

    typedef struct packed {
        logic       rd;
        logic [1:0] kind;
        logic       busy;
        logic [1:0] rsp;
        logic       od;
        logic [5:0] opcode;
    } cmd_fields_t;

    function automatic logic [DATA_W-1:0] cmd_readback(input cmd_fields_t f);
        return DATA_W'({f.rd, 1'b0, f.kind, f.busy, 1'b0, f.rsp, 1'b0, f.od, f.opcode});
    endfunction

endpackage

// File: rtl/sdhost_cmd_launch.sv
module sdhost_cmd_launch
    import sdhost_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_cmd,
    input  cmd_fields_t wr_fields,
    input  logic        eng_busy,
    output logic        start,
    output cmd_fields_t fields
);
    logic accept;
    assign accept = wr_cmd && !eng_busy && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            start  <= 1'b0;
            fields <= '0;
        end else begin
            start <= accept;
            if (accept) fields <= wr_fields;
        end
    end
endmodule

// File: rtl/sdhost_resp_capture.sv
module sdhost_resp_capture
    import sdhost_regs_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  rsp_valid,
    input  logic                                  rsp_long,
    input  logic [RESP_WORDS*DATA_W-1:0]          rsp_data,
    output logic [RESP_WORDS-1:0][DATA_W-1:0]     resp_q
);
    for (genvar i = 0; i < RESP_WORDS; i++) begin : g_word
        logic [DATA_W-1:0] long_word, short_word;
        // word 0 takes the most significant slice of a long response
        assign long_word  = rsp_data[(RESP_WORDS-i)*DATA_W-1 -: DATA_W];
        if (i == 0) begin : g_first
            assign short_word = rsp_data[DATA_W-1:0];
        end else begin : g_rest
            assign short_word = '0;
        end

        always_ff @(posedge clk) begin
            if (rst) resp_q[i] <= '0;
            else if (rsp_valid) resp_q[i] <= rsp_long ? long_word : short_word;
        end
    end
endmodule

// File: rtl/sdhost_irq_status.sv
module sdhost_irq_status
    import sdhost_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_cmd_done,
    input  logic             evt_data_done,
    input  logic             evt_cmd_timeout,
    input  logic             card_present,
    input  logic             card_ro,
    input  logic             clr_we,
    input  logic             en_we,
    input  logic [EVT_W-1:0] wbits,
    output logic [EVT_W-1:0] status_q,
    output logic [EVT_W-1:0] enable_q,
    output logic [1:0]       card_state,
    output logic             irq
);
    logic             present_q, ro_q;
    logic [EVT_W-1:0] set_v, clr_v;

    always_comb begin
        set_v             = '0;
        set_v[B_CMD_END]  = evt_cmd_done && !evt_cmd_timeout;
        set_v[B_DATA_END] = evt_data_done;
        set_v[B_CARD_CHG] = card_present ^ present_q;
        set_v[B_TIMEOUT]  = evt_cmd_timeout;
        clr_v             = clr_we ? wbits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= '0;
            enable_q  <= '0;
            present_q <= 1'b0;
            ro_q      <= 1'b0;
        end else begin
            status_q  <= (status_q & ~clr_v) | set_v;
            if (en_we) enable_q <= wbits;
            present_q <= card_present;
            ro_q      <= card_ro;
        end
    end

    assign card_state = {ro_q, present_q};
    assign irq        = |(status_q & enable_q);
endmodule

// File: rtl/sdhost_regfront.sv
module sdhost_regfront
    import sdhost_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_word_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         cmd_start,
    output logic [5:0]                   cmd_opcode,
    output logic                         cmd_open_drain,
    output logic [1:0]                   cmd_rsp_type,
    output logic                         cmd_busy_rsp,
    output logic [1:0]                   cmd_kind,
    output logic                         cmd_read,
    output logic [DATA_W-1:0]            cmd_arg,
    output logic [DATA_W-1:0]            buf_base,
    output logic [LEN_W-1:0]             blk_len_m1,
    output logic [LEN_W-1:0]             blk_cnt_m1,
    input  logic                         eng_busy,
    input  logic                         evt_cmd_done,
    input  logic                         evt_data_done,
    input  logic                         evt_cmd_timeout,
    input  logic                         rsp_valid,
    input  logic                         rsp_long,
    input  logic [RESP_WORDS*DATA_W-1:0] rsp_data,
    input  logic                         card_present,
    input  logic                         card_ro,
    output logic                         irq
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(W_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(W_ENABLE);
    localparam logic [ADDR_W-1:0] A_BUFFER = ADDR_W'(W_BUFFER);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(W_CMD);
    localparam logic [ADDR_W-1:0] A_ARG    = ADDR_W'(W_ARG);
    localparam logic [ADDR_W-1:0] A_RESP0  = ADDR_W'(W_RESP0);
    localparam logic [ADDR_W-1:0] A_RESP1  = ADDR_W'(W_RESP1);
    localparam logic [ADDR_W-1:0] A_RESP2  = ADDR_W'(W_RESP2);
    localparam logic [ADDR_W-1:0] A_RESP3  = ADDR_W'(W_RESP3);
    localparam logic [ADDR_W-1:0] A_BLKLEN = ADDR_W'(W_BLKLEN);
    localparam logic [ADDR_W-1:0] A_BLKCNT = ADDR_W'(W_BLKCNT);
    localparam logic [ADDR_W-1:0] A_CARD   = ADDR_W'(W_CARD);

    cmd_fields_t                      wr_fields, cur_fields;
    logic [EVT_W-1:0]                 status_q, enable_q;
    logic [1:0]                       card_state;
    logic [RESP_WORDS-1:0][DATA_W-1:0] resp_q;

    assign wr_fields = '{rd: bus_wdata[15], kind: bus_wdata[13:12], busy: bus_wdata[11],
                         rsp: bus_wdata[9:8], od: bus_wdata[6], opcode: bus_wdata[5:0]};

    sdhost_cmd_launch u_launch (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (bus_wr && bus_word_addr == A_CMD),
        .wr_fields (wr_fields),
        .eng_busy  (eng_busy),
        .start     (cmd_start),
        .fields    (cur_fields)
    );

    sdhost_resp_capture u_resp (
        .clk       (clk),
        .rst       (rst),
        .rsp_valid (rsp_valid),
        .rsp_long  (rsp_long),
        .rsp_data  (rsp_data),
        .resp_q    (resp_q)
    );

    sdhost_irq_status u_irq (
        .clk             (clk),
        .rst             (rst),
        .evt_cmd_done    (evt_cmd_done),
        .evt_data_done   (evt_data_done),
        .evt_cmd_timeout (evt_cmd_timeout),
        .card_present    (card_present),
        .card_ro         (card_ro),
        .clr_we          (bus_wr && bus_word_addr == A_STATUS),
        .en_we           (bus_wr && bus_word_addr == A_ENABLE),
        .wbits           (bus_wdata[EVT_W-1:0]),
        .status_q        (status_q),
        .enable_q        (enable_q),
        .card_state      (card_state),
        .irq             (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_arg    <= '0;
            buf_base   <= '0;
            blk_len_m1 <= '0;
            blk_cnt_m1 <= '0;
        end else if (bus_wr) begin
            case (bus_word_addr)
                A_ARG:    cmd_arg    <= bus_wdata;
                A_BUFFER: buf_base   <= bus_wdata;
                A_BLKLEN: blk_len_m1 <= bus_wdata[LEN_W-1:0];
                A_BLKCNT: blk_cnt_m1 <= bus_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    assign cmd_opcode     = cur_fields.opcode;
    assign cmd_open_drain = cur_fields.od;
    assign cmd_rsp_type   = cur_fields.rsp;
    assign cmd_busy_rsp   = cur_fields.busy;
    assign cmd_kind       = cur_fields.kind;
    assign cmd_read       = cur_fields.rd;

    always_comb begin
        case (bus_word_addr)
            A_STATUS: bus_rdata = DATA_W'(status_q);
            A_ENABLE: bus_rdata = DATA_W'(enable_q);
            A_BUFFER: bus_rdata = buf_base;
            A_CMD:    bus_rdata = cmd_readback(cur_fields);
            A_ARG:    bus_rdata = cmd_arg;
            A_RESP0:  bus_rdata = resp_q[0];
            A_RESP1:  bus_rdata = resp_q[1];
            A_RESP2:  bus_rdata = resp_q[2];
            A_RESP3:  bus_rdata = resp_q[3];
            A_BLKLEN: bus_rdata = DATA_W'(blk_len_m1);
            A_BLKCNT: bus_rdata = DATA_W'(blk_cnt_m1);
            A_CARD:   bus_rdata = DATA_W'(card_state);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdhost_regfront_chk.sv
module sdhost_regfront_chk
    import sdhost_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_word_addr,
    input logic              eng_busy,
    input logic              cmd_start,
    input logic              evt_cmd_done,
    input logic              evt_cmd_timeout,
    input logic              card_present,
    input logic [EVT_W-1:0]  status_q,
    input logic [EVT_W-1:0]  enable_q,
    input logic              irq
);
    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !cmd_start);

    a_r4_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word_addr == ADDR_W'(W_CMD) && (eng_busy || cmd_start)) |=> !cmd_start);

    a_r6_done_sets: assert property (@(posedge clk) disable iff (rst)
        (evt_cmd_done && !evt_cmd_timeout) |=> status_q[B_CMD_END]);

    a_r7_timeout_excl: assert property (@(posedge clk) disable iff (rst)
        (evt_cmd_timeout && !status_q[B_CMD_END]) |=> (status_q[B_TIMEOUT] && !status_q[B_CMD_END]));

    a_r8_insert_change: assert property (@(posedge clk) disable iff (rst)
        (!$stable(card_present) && !$past(rst)) |=> status_q[B_CARD_CHG]);

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (enable_q == '0) |-> !irq);
endmodule

bind sdhost_regfront sdhost_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sdhost_regfront.sv
module tb_sdhost_regfront;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_word_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         cmd_start, cmd_open_drain, cmd_busy_rsp, cmd_read;
    logic [5:0]   cmd_opcode;
    logic [1:0]   cmd_rsp_type, cmd_kind;
    logic [31:0]  cmd_arg, buf_base;
    logic [10:0]  blk_len_m1, blk_cnt_m1;
    logic         eng_busy = 1'b0;
    logic         evt_cmd_done = 1'b0, evt_data_done = 1'b0, evt_cmd_timeout = 1'b0;
    logic         rsp_valid = 1'b0, rsp_long = 1'b0;
    logic [127:0] rsp_data = '0;
    logic         card_present = 1'b0, card_ro = 1'b0;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdhost_regfront dut (.*);

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd1,  32'h0000_000A, 32'h0000_000A},
        '{1'b1, 4'd2,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{1'b1, 4'd4,  32'h0BAD_F00D, 32'h0BAD_F00D},
        '{1'b1, 4'd9,  32'hFFFF_F7FF, 32'h0000_07FF},
        '{1'b1, 4'd10, 32'h0000_0000, 32'h0000_0000},
        '{1'b1, 4'd10, 32'h0001_2345, 32'h0000_0345},
        '{1'b0, 4'd12, 32'h0,         32'h0},
        '{1'b0, 4'd15, 32'h0,         32'h0},
        '{1'b1, 4'd5,  32'hFFFF_FFFF, 32'h0},
        '{1'b1, 4'd8,  32'h0000_0001, 32'h0},
        '{1'b1, 4'd11, 32'h0000_0003, 32'h0}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_word_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic d, input logic dd, input logic t);
        @(negedge clk);
        evt_cmd_done = d; evt_data_done = dd; evt_cmd_timeout = t;
        @(negedge clk);
        evt_cmd_done = 1'b0; evt_data_done = 1'b0; evt_cmd_timeout = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "irq", 32'(irq), 0);
        check("R1", "cmd_start", 32'(cmd_start), 0);
        rd(4'd0, v);  check("R1", "status", v, 0);
        rd(4'd3, v);  check("R1", "command word", v, 0);
        rd(4'd11, v); check("R1", "card state", v, 0);

        // R2 / R10 vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            rd(VEC[i].addr, v);
            check(i >= 8 ? "R10" : "R2", $sformatf("vector %0d", i), v, VEC[i].exp);
        end

        // R3 launch with decoded fields
        wr(4'd4, 32'h1234_5678);
        wr(4'd3, 32'hFFFF_B151);
        check("R3", "start pulse", 32'(cmd_start), 1);
        check("R3", "opcode", 32'(cmd_opcode), 32'h11);
        check("R3", "open-drain", 32'(cmd_open_drain), 1);
        check("R3", "rsp type", 32'(cmd_rsp_type), 1);
        check("R3", "busy", 32'(cmd_busy_rsp), 0);
        check("R3", "kind", 32'(cmd_kind), 3);
        check("R3", "read", 32'(cmd_read), 1);
        check("R3", "arg", cmd_arg, 32'h1234_5678);
        @(negedge clk);
        check("R3", "start single cycle", 32'(cmd_start), 0);
        rd(4'd3, v); check("R3", "command readback", v, 32'h0000_B151);

        // R4 ignored while engine busy
        eng_busy = 1'b1;
        wr(4'd3, 32'h0000_0802);
        check("R4", "no start when busy", 32'(cmd_start), 0);
        rd(4'd3, v); check("R4", "word kept when busy", v, 32'h0000_B151);
        eng_busy = 1'b0;

        // R4 ignored while start pulse is high
        @(negedge clk);
        bus_wr = 1'b1; bus_word_addr = 4'd3; bus_wdata = 32'h0000_0A05;
        @(negedge clk);
        bus_wdata = 32'h0000_0802;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R4", "second write no start", 32'(cmd_start), 0);
        rd(4'd3, v); check("R4", "first word kept", v, 32'h0000_0A05);

        // R5 long then short response
        @(negedge clk);
        rsp_valid = 1'b1; rsp_long = 1'b1;
        rsp_data = {32'hAAAA_0003, 32'hBBBB_0002, 32'hCCCC_0001, 32'hDDDD_0000};
        @(negedge clk);
        rsp_valid = 1'b0;
        rd(4'd5, v); check("R5", "long word 5", v, 32'hAAAA_0003);
        rd(4'd6, v); check("R5", "long word 6", v, 32'hBBBB_0002);
        rd(4'd7, v); check("R5", "long word 7", v, 32'hCCCC_0001);
        rd(4'd8, v); check("R5", "long word 8", v, 32'hDDDD_0000);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_long = 1'b0;
        rsp_data = {96'h1, 32'h0000_0900};
        @(negedge clk);
        rsp_valid = 1'b0;
        rd(4'd5, v); check("R5", "short word 5", v, 32'h0000_0900);
        rd(4'd6, v); check("R5", "short word 6", v, 0);
        rd(4'd8, v); check("R5", "short word 8", v, 0);

        // R6 / R9 event sets status and irq, W1C clears
        wr(4'd1, 32'hF);
        pulse(1'b1, 1'b0, 1'b0);
        rd(4'd0, v); check("R6", "cmd end set", v, 32'h1);
        check("R9", "irq on enabled bit", 32'(irq), 1);
        wr(4'd0, 32'h1);
        rd(4'd0, v); check("R6", "cleared", v, 0);
        check("R9", "irq low after clear", 32'(irq), 0);

        // R7 timeout together with command end
        pulse(1'b1, 1'b0, 1'b1);
        rd(4'd0, v); check("R7", "timeout only", v, 32'h8);

        // R6 set wins over simultaneous clear
        pulse(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_word_addr = 4'd0; bus_wdata = 32'hA; evt_data_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_data_done = 1'b0;
        rd(4'd0, v); check("R6", "set wins, other cleared", v, 32'h2);

        // R9 masking
        wr(4'd1, 32'h0);
        check("R9", "irq masked", 32'(irq), 0);
        wr(4'd1, 32'h2);
        check("R9", "irq follows enable", 32'(irq), 1);
        wr(4'd0, 32'hF);

        // R8 card detect
        @(negedge clk); card_present = 1'b1;
        @(negedge clk);
        rd(4'd0, v);  check("R8", "insert change", v, 32'h4);
        rd(4'd11, v); check("R8", "state present", v, 32'h1);
        wr(4'd0, 32'h4);
        @(negedge clk); card_ro = 1'b1;
        @(negedge clk);
        rd(4'd0, v);  check("R8", "ro alone no change", v, 0);
        rd(4'd11, v); check("R8", "state present+ro", v, 32'h3);
        @(negedge clk); card_present = 1'b0;
        @(negedge clk);
        rd(4'd0, v);  check("R8", "removal change", v, 32'h4);
        rd(4'd11, v); check("R8", "state ro only", v, 32'h2);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule